// File: doc/BRIEF.md
# Serial Port Interrupt Identification and Priority Encoder

This block gathers the interrupt sources of a serial port controller, masks each with its enable bit and reports the most urgent one. It drives an active-high interrupt request and a combinational identification byte that the register bank returns when software reads the identification register. The source conditions come from neighbouring blocks: line-status and modem-status events arrive as one-cycle pulses and are held here until serviced. Receive data and receive timeout arrive as levels. The holding-register-empty condition arrives as a level, and the block turns it into a held interrupt.

Clearing follows the usual register side effects. The register bank passes these to the block as one-cycle strobes: a line status read, a modem status read, a write to the transmit buffer, and a read of the identification register. The last of these clears the transmit-empty interrupt only when that interrupt is the one being reported.

Top module: `uart_int_prio`

## Requirements
- R1: After reset no interrupt is held, `irq` is 0 and `identByte` bit 0 is 1.
- R2: The interrupt state in `identByte[2:1]` is 11 for line status (highest), 10 for received data, 01 for transmit empty and 00 for modem status (lowest). When several enabled sources are active, the highest one is reported. The field is 00 when nothing is pending.
- R3: A source takes part only when its `enMask` bit is 1. The bits are: bit 0 received data and timeout, bit 1 transmit empty, bit 2 line status, bit 3 modem status.
- R4: `identByte[0]` is 0 when any enabled source is active and 1 otherwise. `irq` is 1 exactly when an enabled source is active.
- R5: An enabled receive timeout is reported with state 10 and `identByte[3]` set. It has the same priority as received data. Bit 3 is 0 whenever state 10 is not reported.
- R6: `identByte[7:6]` always equals `fifoState`, and `identByte[5:4]` is always 0.
- R7: A `lineEvt` pulse holds the line-status interrupt from the next cycle on. `rdLineStat` clears it the cycle after. A set and a clear in the same cycle leave it set.
- R8: A `modemEvt` pulse holds the modem interrupt from the next cycle on. `rdModemStat` clears it, with the same set-wins rule.
- R9: A 0-to-1 change of `thrEmpty` holds the transmit-empty interrupt from the next cycle on. `wrThr` clears it.
- R10: `rdIdent` clears the transmit-empty interrupt only in a cycle where state 01 is being reported. A read that returns another state leaves it held.
- R11: When `enMask[1]` goes from 0 to 1 while `thrEmpty` is 1, the transmit-empty interrupt is held again.
- R12: Received data and timeout are not held: they follow `rxAvail` and `rxTimeout` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enMask | input | 4 | Interrupt enable bits |
| lineEvt | input | 1 | Line error or break event pulse |
| rxAvail | input | 1 | Receive data at or above trigger level |
| rxTimeout | input | 1 | Character timeout condition |
| thrEmpty | input | 1 | Transmit holding register empty |
| modemEvt | input | 1 | Modem line change pulse |
| wrThr | input | 1 | Transmit buffer write strobe |
| rdIdent | input | 1 | Identification register read strobe |
| rdLineStat | input | 1 | Line status read strobe |
| rdModemStat | input | 1 | Modem status read strobe |
| fifoState | input | 2 | FIFO state bits shown in the byte |
| identByte | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
Directed cases build up sources one above another. This shows that the priority order holds, that a lower interrupt reappears when a higher one is cleared, and that reading the identification register while line status is shown leaves transmit-empty held. Masking and unmasking of a held source separates the enable gating from clearing. Toggling the transmit-empty enable shows the re-arm. Random runs with sparse event pulses and frequent strobes hit same-cycle set and clear collisions and every mix of sources. These are compared cycle by cycle against a model built from the requirements.

// File: rtl/uart_int_pkg.sv
package uart_int_pkg;
  localparam int ENW = 4;
  localparam int FSW = 2;
  localparam int IDW = 8;
  localparam int EN_RX = 0;
  localparam int EN_THR = 1;
  localparam int EN_LS = 2;
  localparam int EN_MS = 3;

  typedef enum logic [1:0] {
    CODE_MS  = 2'b00,
    CODE_THR = 2'b01,
    CODE_RX  = 2'b10,
    CODE_LS  = 2'b11
  } intCode_t;

  typedef struct packed {
    logic lsSet;
    logic lsClr;
    logic msSet;
    logic msClr;
    logic thrSet;
    logic thrClr;
  } intStrobe_t;
endpackage

// File: rtl/uart_int_ctrl.sv
module uart_int_ctrl
  import uart_int_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [ENW-1:0] enMask,
  input  logic           lineEvt,
  input  logic           modemEvt,
  input  logic           thrEmpty,
  input  logic           wrThr,
  input  logic           rdIdent,
  input  logic           rdLineStat,
  input  logic           rdModemStat,
  input  logic           thrShown,
  output intStrobe_t     strb
);
  logic thrEmptyQ;
  logic enThrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrEmptyQ <= 1'b0;
      enThrQ    <= 1'b0;
    end else begin
      thrEmptyQ <= thrEmpty;
      enThrQ    <= enMask[EN_THR];
    end
  end

  always_comb begin
    strb.lsSet  = lineEvt;
    strb.lsClr  = rdLineStat;
    strb.msSet  = modemEvt;
    strb.msClr  = rdModemStat;
    strb.thrSet = thrEmpty & (~thrEmptyQ | (enMask[EN_THR] & ~enThrQ));
    strb.thrClr = wrThr | (rdIdent & thrShown);
  end

  // R7 / R8: the strobes pass through unaltered in the same cycle
  assert_ls_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    lineEvt |-> strb.lsSet);
  assert_ms_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdModemStat |-> strb.msClr);
endmodule

// File: rtl/uart_int_dp.sv
module uart_int_dp
  import uart_int_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  intStrobe_t     strb,
  input  logic [ENW-1:0] enMask,
  input  logic           rxAvail,
  input  logic           rxTimeout,
  input  logic [FSW-1:0] fifoState,
  output logic [IDW-1:0] identByte,
  output logic           irq,
  output logic           thrShown
);
  logic lsPend, msPend, thrPend;
  logic lsAct, rxAct, thrAct, msAct;
  intCode_t code;
  logic toFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lsPend  <= 1'b0;
      msPend  <= 1'b0;
      thrPend <= 1'b0;
    end else begin
      if (strb.lsSet) lsPend <= 1'b1;
      else if (strb.lsClr) lsPend <= 1'b0;
      if (strb.msSet) msPend <= 1'b1;
      else if (strb.msClr) msPend <= 1'b0;
      if (strb.thrSet) thrPend <= 1'b1;
      else if (strb.thrClr) thrPend <= 1'b0;
    end
  end

  always_comb begin
    lsAct  = enMask[EN_LS] & lsPend;
    rxAct  = enMask[EN_RX] & (rxAvail | rxTimeout);
    thrAct = enMask[EN_THR] & thrPend;
    msAct  = enMask[EN_MS] & msPend;
    code   = CODE_MS;
    toFlag = 1'b0;
    if (lsAct) code = CODE_LS;
    else if (rxAct) begin
      code   = CODE_RX;
      toFlag = rxTimeout;
    end else if (thrAct) code = CODE_THR;
    irq      = lsAct | rxAct | thrAct | msAct;
    thrShown = thrAct & ~lsAct & ~rxAct;
    identByte = {fifoState, 2'b00, toFlag, code, ~irq};
  end

  // R7: a line status read with no new event drops the held interrupt
  assert_ls_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lsClr && !strb.lsSet) |=> !lsPend);
  // R9: a set pulse holds transmit-empty
  assert_thr_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.thrSet |=> thrPend);
  // R3: with every enable clear nothing is requested
  assert_masked_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enMask == '0) |-> !irq);
  // R12: received data follows its level without delay
  assert_rx_level_R12: assert property (@(posedge clk) disable iff (!rstN)
    (enMask[EN_RX] && rxAvail && !lsPend) |-> (identByte[2:1] == CODE_RX));
endmodule

// File: rtl/uart_int_prio.sv
module uart_int_prio
  import uart_int_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [ENW-1:0] enMask,
  input  logic           lineEvt,
  input  logic           rxAvail,
  input  logic           rxTimeout,
  input  logic           thrEmpty,
  input  logic           modemEvt,
  input  logic           wrThr,
  input  logic           rdIdent,
  input  logic           rdLineStat,
  input  logic           rdModemStat,
  input  logic [FSW-1:0] fifoState,
  output logic [IDW-1:0] identByte,
  output logic           irq
);
  intStrobe_t strb;
  logic thrShown;

  uart_int_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .enMask(enMask), .lineEvt(lineEvt),
    .modemEvt(modemEvt), .thrEmpty(thrEmpty), .wrThr(wrThr),
    .rdIdent(rdIdent), .rdLineStat(rdLineStat), .rdModemStat(rdModemStat),
    .thrShown(thrShown), .strb(strb)
  );

  uart_int_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .enMask(enMask),
    .rxAvail(rxAvail), .rxTimeout(rxTimeout), .fifoState(fifoState),
    .identByte(identByte), .irq(irq), .thrShown(thrShown)
  );

  // R11: enabling transmit-empty while the register is empty raises it
  assert_rearm_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(enMask[EN_THR]) && thrEmpty && $past(rstN) && !wrThr)
      |=> (enMask[EN_THR] ? irq : 1'b1));
  // R10: reading the byte while line status is shown keeps transmit-empty
  assert_read_keep_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdent && identByte[2:1] == CODE_LS && !identByte[0] && !wrThr && !rdLineStat
     && enMask[EN_THR] && i_dp.thrPend) |=> ($stable(enMask) -> irq));
endmodule

// File: tb/test_uart_int_prio.sv
`timescale 1ns/100ps
module test_uart_int_prio;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] enMask = '0;
  logic lineEvt = 0, rxAvail = 0, rxTimeout = 0, thrEmpty = 0, modemEvt = 0;
  logic wrThr = 0, rdIdent = 0, rdLineStat = 0, rdModemStat = 0;
  logic [1:0] fifoState = 2'b11;
  logic [7:0] identByte;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_int_prio i_uart_int_prio (
    .clk(clk), .rstN(rstN), .enMask(enMask), .lineEvt(lineEvt),
    .rxAvail(rxAvail), .rxTimeout(rxTimeout), .thrEmpty(thrEmpty),
    .modemEvt(modemEvt), .wrThr(wrThr), .rdIdent(rdIdent),
    .rdLineStat(rdLineStat), .rdModemStat(rdModemStat),
    .fifoState(fifoState), .identByte(identByte), .irq(irq)
  );

  // Model state built from the requirements
  logic mLs = 0, mMs = 0, mThr = 0, mEmptyQ = 0, mEnQ = 0;

  function automatic logic [8:0] expOut(logic ls, logic ms, logic thr);
    logic lsA, rxA, thrA, msA, any, to;
    logic [1:0] c;
    lsA = enMask[2] & ls;
    rxA = enMask[0] & (rxAvail | rxTimeout);
    thrA = enMask[1] & thr;
    msA = enMask[3] & ms;
    any = lsA | rxA | thrA | msA;
    to = 1'b0;
    c = 2'b00;
    if (lsA) c = 2'b11;
    else if (rxA) begin c = 2'b10; to = rxTimeout; end
    else if (thrA) c = 2'b01;
    return {any, fifoState, 2'b00, to, c, ~any};
  endfunction

  always @(posedge clk) begin
    logic [8:0] e;
    logic tSet, tClr;
    if (!rstN) begin
      mLs <= 0; mMs <= 0; mThr <= 0; mEmptyQ <= 0; mEnQ <= 0;
    end else begin
      e = expOut(mLs, mMs, mThr);
      tSet = thrEmpty & (~mEmptyQ | (enMask[1] & ~mEnQ));
      tClr = wrThr | (rdIdent & e[8] & e[2:1] == 2'b01);
      if (lineEvt) mLs <= 1; else if (rdLineStat) mLs <= 0;
      if (modemEvt) mMs <= 1; else if (rdModemStat) mMs <= 0;
      if (tSet) mThr <= 1; else if (tClr) mThr <= 0;
      mEmptyQ <= thrEmpty;
      mEnQ <= enMask[1];
    end
  end

  task automatic check(string tag);
    logic [8:0] e;
    e = expOut(mLs, mMs, mThr);
    checks++;
    if ({irq, identByte} !== e) begin
      errors++;
      $display("FAIL %s: irq/ident actual %b/%h expected %b/%h", tag, irq, identByte, e[8], e[7:0]);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    lineEvt = 0; modemEvt = 0; wrThr = 0; rdIdent = 0; rdLineStat = 0; rdModemStat = 0;
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    checks++;
    if (identByte !== 8'hC1 || irq !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual %h/%b expected c1/0", identByte, irq);
    end
    enMask = 4'b0010; thrEmpty = 1;                 step(); check("R9 thr set");
    enMask = 4'b0011; rxAvail = 1;                  #1 check("R2 rx over thr, R12");
    rxTimeout = 1;                                  #1 check("R5 timeout flag");
    enMask = 4'b0111; lineEvt = 1;                  step(); check("R7 line set, R2 top");
    rdIdent = 1;                                    step(); check("R10 read shows line");
    rdLineStat = 1;                                 step(); check("R7 line cleared");
    rxAvail = 0; rxTimeout = 0;                     #1 check("R10 thr kept, R12 follows");
    rdIdent = 1;                                    step(); check("R10 thr cleared by read");
    enMask = 4'b0101;                               step();
    enMask = 4'b0111;                               step(); check("R11 rearm");
    wrThr = 1;                                      step(); check("R9 write clears");
    enMask = 4'b1111; modemEvt = 1;                 step(); check("R8 modem low priority");
    enMask = 4'b0111;                               #1 check("R3 modem masked");
    enMask = 4'b1111;                               #1 check("R3 modem unmasked");
    rdModemStat = 1;                                step(); check("R8 modem cleared");
    fifoState = 2'b01;                              #1 check("R6 fifo bits");
    enMask = 4'b0100; lineEvt = 1; rdLineStat = 1;  step(); check("R7 set wins");
    enMask = 4'b0000;                               #1 check("R4 nothing enabled");
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 9) == 0) enMask = 4'($urandom);
      lineEvt = ($urandom_range(0, 15) == 0);
      modemEvt = ($urandom_range(0, 15) == 0);
      rxAvail = ($urandom_range(0, 3) == 0);
      rxTimeout = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 7) == 0) thrEmpty = ~thrEmpty;
      wrThr = ($urandom_range(0, 7) == 0);
      rdIdent = ($urandom_range(0, 2) == 0);
      rdLineStat = ($urandom_range(0, 5) == 0);
      rdModemStat = ($urandom_range(0, 5) == 0);
      fifoState = 2'($urandom);
      #1 check("R2 random mix");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule